// File: doc/BRIEF.md
# Debug Pin Synchronization Responder

This block sits on the target side of an open-drain, bidirectional single-wire debug pin. It samples the pin and watches for a low pulse longer than any legal data bit, which the host uses to ask for synchronization. When such a request is seen, it sends a one-cycle soft-reset to the command shifter, so a half-received command or bit is thrown away. If an acknowledge pulse is pending at that moment, the block also cancels it.

After the request, the block waits for the host to let the pin rise. It then leaves a short guard gap so the host can stop its own speed-up drive. Next it pulls the pin low for a fixed number of its own communication clocks, drives the pin high for one cycle to give a sharp rising edge, and then lets go of the pin. The host times that low pulse to learn the target's communication speed. Once the pin is released, the next falling edge is reported as the start of a new transfer, which may be a command or another request.

Top module: `sync_pulse_responder`

## Requirements
- R1: While reset is held, drv_en, drv_val, busy, soft_rst, ack_abort and cmd_start are all 0.
- R2: A falling edge on the synchronized pin while idle pulses cmd_start for one cycle. A low run shorter than LOW_THRESH clocks (counted at pin_in) raises no request and drives nothing.
- R3: If pin_in is sampled low on LOW_THRESH consecutive edges, soft_rst pulses for exactly one cycle. The pulse appears LOW_THRESH+1 edges after the first edge that sampled the pin low.
- R4: ack_abort pulses in the same cycle as soft_rst if and only if ack_pend was 1 in the cycle the request was detected.
- R5: After a request, nothing is driven while the host keeps the pin low.
- R6: The first edge that samples pin_in high again starts a delay. After this delay the low drive begins: drv_en becomes 1 after the (2+GUARD_CYC)th edge that follows it. No drive occurs during the guard gap.
- R7: The low reply lasts exactly REPLY_CYC cycles, with drv_en=1 and drv_val=0.
- R8: The low reply is followed by exactly one cycle with drv_en=1 and drv_val=1. After that cycle drv_en is 0.
- R9: busy is 1 from the cycle soft_rst pulses to the speed-up cycle inclusive, and 0 at all other times.
- R10: After the reply, the pin's own trailing low samples do not count as an edge. The next host falling edge gives cmd_start and can start a new request.
- R11: Falling edges seen while busy, including the one caused by the block's own reply, do not produce cmd_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Communication clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw level read back from the debug pin |
| ack_pend | input | 1 | An acknowledge pulse is pending in the command logic |
| drv_en | output | 1 | Pin output enable; 0 means high impedance |
| drv_val | output | 1 | Level driven on the pin while drv_en is 1 |
| soft_rst | output | 1 | One-cycle abort to the command shifter |
| ack_abort | output | 1 | One-cycle cancel of the pending acknowledge |
| cmd_start | output | 1 | A falling edge started a new transfer |
| busy | output | 1 | A request is being served |

## Verification
All results are counted from the first clock edge that sees the new pin level, with two synchronizer flops in the path. For a host low time of L cycles, the expected timing is:

| Result | Due at edge |
|---|---|
| cmd_start | 2 |
| soft_rst and ack_abort (a request exists when L ≥ LOW_THRESH) | LOW_THRESH+2 |
| drive enable | L+3+GUARD_CYC |
| drive enable ends | after L+3+GUARD_CYC+REPLY_CYC, which is the speed-up cycle |

The bench sweeps every host low time across the threshold, with and without a pending acknowledge. It computes these cycle numbers arithmetically. At each falling clock edge it compares every output with the value expected for that cycle number, so an event that is one cycle early or late fails.

// File: rtl/srsp_pkg.sv
package srsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITHI,
    ST_GUARD,
    ST_REPLY,
    ST_BOOST
  } srsp_state_t;
endpackage

// File: rtl/srsp_pin_sync.sv
module srsp_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_lvl,
  output logic pin_prev
);
  logic [SYNC_STAGES-1:0] sff;

  // stage 0 takes the raw pin; later stages shift; idle level is high
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sff[i] <= 1'b1;
        else        sff[i] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sff[i] <= 1'b1;
        else        sff[i] <= sff[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b1;
    else        pin_prev <= sff[SYNC_STAGES-1];
  end

  assign pin_lvl = sff[SYNC_STAGES-1];
endmodule

// File: rtl/srsp_low_timer.sv
module srsp_low_timer #(
  parameter int LOW_THRESH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic pin_lvl,
  input  logic pin_prev,
  output logic fall,
  output logic req
);
  localparam int CW = $clog2(LOW_THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_THRESH - 1);
  localparam logic [CW-1:0] TOP  = CW'(LOW_THRESH);

  logic [CW-1:0] run_q, run_d;

  assign fall = idle && pin_prev && !pin_lvl;

  always_comb begin
    run_d = run_q;
    if (!idle)                          run_d = '0;
    else if (fall)                      run_d = CW'(1);
    else if (pin_lvl)                   run_d = '0;
    else if (run_q != '0 && run_q < TOP) run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign req = idle && !pin_lvl && (run_q == LAST);

  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= TOP);
  assert_high_clears_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pin_lvl && !fall) |=> run_q == '0);
endmodule

// File: rtl/srsp_reply_fsm.sv
module srsp_reply_fsm
  import srsp_pkg::*;
#(
  parameter int GUARD_CYC = 16,
  parameter int REPLY_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack_pend,
  input  logic pin_lvl,
  output logic idle,
  output logic drv_en,
  output logic drv_val,
  output logic busy,
  output logic soft_rst,
  output logic ack_abort
);
  localparam int MAXC = (GUARD_CYC > REPLY_CYC) ? GUARD_CYC : REPLY_CYC;
  localparam int PW   = $clog2(MAXC + 1);
  localparam logic [PW-1:0] G_END = PW'(GUARD_CYC - 1);
  localparam logic [PW-1:0] R_END = PW'(REPLY_CYC - 1);

  srsp_state_t st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic sr_d, ab_d;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    sr_d = 1'b0;
    ab_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        ph_d = '0;
        if (req) begin
          st_d = ST_WAITHI;
          sr_d = 1'b1;
          ab_d = ack_pend;
        end
      end
      ST_WAITHI: begin
        ph_d = '0;
        if (pin_lvl) st_d = ST_GUARD;
      end
      ST_GUARD: begin
        if (ph_q == G_END) begin
          st_d = ST_REPLY;
          ph_d = '0;
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end
      ST_REPLY: begin
        if (ph_q == R_END) begin
          st_d = ST_BOOST;
          ph_d = '0;
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end
      ST_BOOST: begin
        st_d = ST_IDLE;
        ph_d = '0;
      end
      default: begin
        st_d = ST_IDLE;
        ph_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ph_q      <= '0;
      soft_rst  <= 1'b0;
      ack_abort <= 1'b0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      soft_rst  <= sr_d;
      ack_abort <= ab_d;
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign busy    = !idle;
  assign drv_en  = (st_q == ST_REPLY) || (st_q == ST_BOOST);
  assign drv_val = (st_q == ST_BOOST);

  assert_soft_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  assert_abort_with_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_abort |-> soft_rst);
  assert_hold_while_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAITHI && !pin_lvl) |=> (st_q == ST_WAITHI && !drv_en));
  assert_guard_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GUARD) |-> ph_q <= G_END);
  assert_reply_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REPLY) |-> ph_q <= R_END);
  assert_boost_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |=> (!drv_en && !busy));
  assert_busy_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> soft_rst);
endmodule

// File: rtl/sync_pulse_responder.sv
module sync_pulse_responder #(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_THRESH  = 64,
  parameter int GUARD_CYC   = 16,
  parameter int REPLY_CYC   = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic ack_pend,
  output logic drv_en,
  output logic drv_val,
  output logic soft_rst,
  output logic ack_abort,
  output logic cmd_start,
  output logic busy
);
  logic pin_lvl, pin_prev, idle, fall, req;

  srsp_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .pin_lvl(pin_lvl), .pin_prev(pin_prev)
  );

  srsp_low_timer #(.LOW_THRESH(LOW_THRESH)) u_timer (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .pin_lvl(pin_lvl), .pin_prev(pin_prev),
    .fall(fall), .req(req)
  );

  srsp_reply_fsm #(.GUARD_CYC(GUARD_CYC), .REPLY_CYC(REPLY_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .ack_pend(ack_pend),
    .pin_lvl(pin_lvl), .idle(idle), .drv_en(drv_en), .drv_val(drv_val),
    .busy(busy), .soft_rst(soft_rst), .ack_abort(ack_abort)
  );

  assign cmd_start = fall;

  assert_release_after_boost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(drv_en && drv_val));
  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_start);
endmodule

// File: tb/sync_pulse_responder_bench.sv
module sync_pulse_responder_bench;
  localparam int TH = 6;
  localparam int GD = 3;
  localparam int RP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_lvl = 1'b1;
  logic ack_pend = 1'b0;
  logic pin_in;
  logic drv_en, drv_val, soft_rst, ack_abort, cmd_start, busy;
  int n_run = 0;
  int n_fail = 0;

  assign pin_in = drv_en ? drv_val : host_lvl;

  always #4 clk = ~clk;

  sync_pulse_responder #(
    .SYNC_STAGES(2), .LOW_THRESH(TH), .GUARD_CYC(GD), .REPLY_CYC(RP)
  ) u_sync_pulse_responder (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ack_pend(ack_pend),
    .drv_en(drv_en), .drv_val(drv_val), .soft_rst(soft_rst),
    .ack_abort(ack_abort), .cmd_start(cmd_start), .busy(busy)
  );

  task automatic chk(string tag, string what, int cyc, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", tag, what, cyc, got, exp);
    end
  endtask

  // host holds pin low for L cycles; checks every output on every cycle
  task automatic run_trial(int L, bit a);
    bit rq;
    int last;
    rq = (L >= TH);
    last = rq ? (L + GD + RP + 6) : (L + TH + 4);
    ack_pend = a;
    @(negedge clk);
    host_lvl = 1'b0;
    for (int n = 1; n <= last; n++) begin
      bit e_sr, e_ab, e_bz, e_de, e_dv, e_cs;
      @(negedge clk);
      e_cs = (n == 2);
      e_sr = rq && (n == TH + 2);
      e_ab = e_sr && a;
      e_bz = rq && (n >= TH + 2) && (n <= L + 3 + GD + RP);
      e_de = rq && (n >= L + 3 + GD) && (n <= L + 3 + GD + RP);
      e_dv = rq && (n == L + 3 + GD + RP);
      if (!rq) begin
        chk("R2", "drv_en", n, drv_en, 1'b0);
        chk("R2", "busy", n, busy, 1'b0);
        chk("R2", "soft_rst", n, soft_rst, 1'b0);
        chk("R2", "cmd_start", n, cmd_start, e_cs);
      end else begin
        chk("R3", "soft_rst", n, soft_rst, e_sr);
        chk("R4", "ack_abort", n, ack_abort, e_ab);
        chk("R9", "busy", n, busy, e_bz);
        if (n < L + 3 + GD)
          chk(n <= L ? "R5" : "R6", "drv_en", n, drv_en, e_de);
        else if (n < L + 3 + GD + RP)
          chk("R7", "drv_en", n, drv_en, e_de);
        else
          chk("R8", "drv_en", n, drv_en, e_de);
        chk("R8", "drv_val", n, drv_val, e_dv);
        if (n == 2)       chk("R2", "cmd_start", n, cmd_start, e_cs);
        else if (e_bz)    chk("R11", "cmd_start", n, cmd_start, e_cs);
        else              chk("R10", "cmd_start", n, cmd_start, e_cs);
      end
      if (n == L) host_lvl = 1'b1;
    end
    ack_pend = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "drv_en", 0, drv_en, 1'b0);
    chk("R1", "drv_val", 0, drv_val, 1'b0);
    chk("R1", "busy", 0, busy, 1'b0);
    chk("R1", "soft_rst", 0, soft_rst, 1'b0);
    chk("R1", "ack_abort", 0, ack_abort, 1'b0);
    chk("R1", "cmd_start", 0, cmd_start, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int L = 1; L <= TH + 4; L++) begin
      for (int a = 0; a < 2; a++) begin
        run_trial(L, a[0]);
        repeat (2) @(negedge clk);
      end
    end
    // R10: a request issued right after a reply with no idle gap in between
    run_trial(TH, 1'b1);
    run_trial(TH + 1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule